// File: doc/BRIEF.md
# Butterfly Bit-Permutation Unit (reverse, OR-combine, shuffle)

This combinational unit rearranges the bits of a 64-bit word through a chain of butterfly stages. Each stage is gated by one bit of a small control amount. Four operations share the hardware. The generalized reverse moves every bit to the position given by its index XOR the amount. The generalized OR-combine merges each bit with its butterfly partners. The perfect shuffle interleaves bit groups, and the inverse shuffle undoes that interleaving.

The control amount comes either from the low bits of a register operand or from a short immediate field, so one datapath serves both operand forms. A narrow select limits the operation to the low 32 bits and zero-extends the result. An execution pipeline places the unit where it has one cycle of combinational budget and registers the result outside the block.

Top module: `permUnit`

## Requirements
- R1: With modeSel = 0 (reverse), resultOut bit i equals dataIn bit (i XOR k), where k is the effective control amount.
- R2: With modeSel = 1 (OR-combine), resultOut bit i is the OR of all dataIn bits j for which i and j differ only in bit positions that are set in k.
- R3: With modeSel = 2 (shuffle), the stage gated by amount bit s exchanges index bits s and s+1 of every bit position. The stages run in order from s = 4 down to s = 0.
- R4: With modeSel = 3 (inverse shuffle), the same stages run from s = 0 up to s = 4. For every k, applying the inverse shuffle to the result of the shuffle returns the original word.
- R5: With narrowSel = 1, resultOut[63:32] is zero and the result depends only on dataIn[31:0].
- R6: The effective amount k keeps 6 bits of the selected control value for modes 0 and 1, and 5 bits for modes 2 and 3. With narrowSel = 1 it keeps 5 and 4 bits respectively. Higher control bits have no effect.
- R7: With useImm = 1 the amount comes from ctrlImm and ctrlReg is ignored. With useImm = 0 it comes from ctrlReg[5:0] and ctrlImm is ignored.
- R8: With an effective amount of zero, every mode returns dataIn (the low half only when narrowSel = 1).
- R9: The reverse mode with k = 63 and narrowSel = 0 reverses the bit order of the whole word.
- R10: The OR-combine mode with k = 63 returns all ones for any nonzero word and zero for a zero word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dataIn | input | 64 | Word to permute |
| ctrlReg | input | 64 | Register operand; its low bits supply the amount when useImm = 0 |
| ctrlImm | input | 6 | Immediate amount, used when useImm = 1 |
| useImm | input | 1 | Selects the amount source |
| modeSel | input | 2 | 0 reverse, 1 OR-combine, 2 shuffle, 3 inverse shuffle |
| narrowSel | input | 1 | 32-bit operation with the upper half cleared |
| resultOut | output | 64 | Permuted word |

## Verification
Because the unit holds no state, any fault in a stage enable or a mask shows at resultOut for the same input vector. Nothing propagates into later cycles. A stage gated by the wrong amount bit, or a shuffle chain run in the wrong order, breaks the bit-position mapping only for amounts that set the affected bits. The bench therefore sweeps all 64 amounts in every mode at both widths. A fault that leaks the upper half into the narrow form shows as nonzero high bits as soon as the data carries ones there.

// File: rtl/permPkg.sv
package permPkg;
  localparam int XLEN = 64;
  localparam int LG = $clog2(XLEN);
  localparam int SHUF_STAGES = LG - 1;
  localparam int HALF = XLEN / 2;

  typedef enum logic [1:0] {
    MODE_GREV   = 2'd0,
    MODE_GORC   = 2'd1,
    MODE_SHFL   = 2'd2,
    MODE_UNSHFL = 2'd3
  } permMode_e;

  typedef struct packed {
    logic [LG-1:0]          flipEn;    // butterfly stages for reverse/OR-combine
    logic                   orMerge;   // OR swapped copy into data
    logic [SHUF_STAGES-1:0] shufEn;    // shuffle stages
    logic                   shufPath;  // take the shuffle result
    logic                   invOrder;  // smallest distance first
    logic                   clearHigh; // narrow form
  } permStrobes_t;

  // Bits that sit in the lower group of each pair of 2^k-bit groups.
  function automatic logic [XLEN-1:0] flipLowMask(input int k);
    logic [XLEN-1:0] m;
    for (int i = 0; i < XLEN; i++) m[i] = ((i >> k) & 1) == 0;
    return m;
  endfunction

  // Shuffle stage k: destination of the left shift (index bits k+1,k = 1,0).
  function automatic logic [XLEN-1:0] shufLeftMask(input int k);
    logic [XLEN-1:0] m;
    for (int i = 0; i < XLEN; i++) m[i] = (((i >> (k + 1)) & 1) == 1) && (((i >> k) & 1) == 0);
    return m;
  endfunction

  // Shuffle stage k: destination of the right shift (index bits k+1,k = 0,1).
  function automatic logic [XLEN-1:0] shufRightMask(input int k);
    logic [XLEN-1:0] m;
    for (int i = 0; i < XLEN; i++) m[i] = (((i >> (k + 1)) & 1) == 0) && (((i >> k) & 1) == 1);
    return m;
  endfunction
endpackage

// File: rtl/permCtrl.sv
module permCtrl
  import permPkg::*;
(
  input  logic [XLEN-1:0] ctrlReg,
  input  logic [LG-1:0]   ctrlImm,
  input  logic            useImm,
  input  logic [1:0]      modeSel,
  input  logic            narrowSel,
  output permStrobes_t    strobes
);
  localparam logic [LG-1:0] FULL_FLIP = '1;
  localparam logic [LG-1:0] NARROW_FLIP = FULL_FLIP >> 1;
  localparam logic [SHUF_STAGES-1:0] FULL_SHUF = '1;
  localparam logic [SHUF_STAGES-1:0] NARROW_SHUF = FULL_SHUF >> 1;

  logic [LG-1:0] amtRaw;
  logic [LG-1:0] flipKeep;
  logic [SHUF_STAGES-1:0] shufKeep;
  permMode_e mode;

  always_comb begin
    mode = permMode_e'(modeSel);
    amtRaw = useImm ? ctrlImm : ctrlReg[LG-1:0];
    flipKeep = narrowSel ? NARROW_FLIP : FULL_FLIP;
    shufKeep = narrowSel ? NARROW_SHUF : FULL_SHUF;

    strobes = '0;
    strobes.clearHigh = narrowSel;
    unique case (mode)
      MODE_GREV: strobes.flipEn = amtRaw & flipKeep;
      MODE_GORC: begin
        strobes.flipEn = amtRaw & flipKeep;
        strobes.orMerge = 1'b1;
      end
      MODE_SHFL: begin
        strobes.shufEn = amtRaw[SHUF_STAGES-1:0] & shufKeep;
        strobes.shufPath = 1'b1;
      end
      MODE_UNSHFL: begin
        strobes.shufEn = amtRaw[SHUF_STAGES-1:0] & shufKeep;
        strobes.shufPath = 1'b1;
        strobes.invOrder = 1'b1;
      end
      default: strobes = '0;
    endcase
  end
endmodule

// File: rtl/permDatapath.sv
module permDatapath
  import permPkg::*;
(
  input  logic [XLEN-1:0] dataIn,
  input  permStrobes_t    strobes,
  output logic [XLEN-1:0] resultOut
);
  logic [XLEN-1:0] flipChain [LG+1];
  logic [XLEN-1:0] fwdChain [SHUF_STAGES+1];
  logic [XLEN-1:0] invChain [SHUF_STAGES+1];
  logic [XLEN-1:0] picked;

  assign flipChain[0] = dataIn;
  assign fwdChain[0] = dataIn;
  assign invChain[0] = dataIn;

  // Butterfly stages, smallest distance first.
  for (genvar k = 0; k < LG; k++) begin : g_flip
    localparam logic [XLEN-1:0] LOW_M = flipLowMask(k);
    localparam int DIST = 1 << k;
    logic [XLEN-1:0] swapped;
    assign swapped = ((flipChain[k] & LOW_M) << DIST) | ((flipChain[k] & ~LOW_M) >> DIST);
    assign flipChain[k+1] = !strobes.flipEn[k] ? flipChain[k]
                          : strobes.orMerge ? (flipChain[k] | swapped) : swapped;
  end

  // Shuffle: the forward chain runs the largest distance first, the inverse chain the smallest.
  for (genvar j = 0; j < SHUF_STAGES; j++) begin : g_shuf
    localparam int KF = SHUF_STAGES - 1 - j;
    localparam int KI = j;
    localparam logic [XLEN-1:0] LF = shufLeftMask(KF);
    localparam logic [XLEN-1:0] RF = shufRightMask(KF);
    localparam logic [XLEN-1:0] LI = shufLeftMask(KI);
    localparam logic [XLEN-1:0] RI = shufRightMask(KI);
    localparam int DF = 1 << KF;
    localparam int DI = 1 << KI;
    logic [XLEN-1:0] fwdNext;
    logic [XLEN-1:0] invNext;
    assign fwdNext = (fwdChain[j] & ~(LF | RF)) | ((fwdChain[j] << DF) & LF) | ((fwdChain[j] >> DF) & RF);
    assign invNext = (invChain[j] & ~(LI | RI)) | ((invChain[j] << DI) & LI) | ((invChain[j] >> DI) & RI);
    assign fwdChain[j+1] = strobes.shufEn[KF] ? fwdNext : fwdChain[j];
    assign invChain[j+1] = strobes.shufEn[KI] ? invNext : invChain[j];
  end

  always_comb begin
    if (strobes.shufPath) picked = strobes.invOrder ? invChain[SHUF_STAGES] : fwdChain[SHUF_STAGES];
    else picked = flipChain[LG];
    resultOut = strobes.clearHigh ? {{(XLEN-HALF){1'b0}}, picked[HALF-1:0]} : picked;
  end
endmodule

// File: rtl/permUnit.sv
module permUnit
  import permPkg::*;
(
  input  logic [63:0] dataIn,
  input  logic [63:0] ctrlReg,
  input  logic [5:0]  ctrlImm,
  input  logic        useImm,
  input  logic [1:0]  modeSel,
  input  logic        narrowSel,
  output logic [63:0] resultOut
);
  permStrobes_t strobes;

  permCtrl u_ctrl (
    .ctrlReg(ctrlReg), .ctrlImm(ctrlImm), .useImm(useImm),
    .modeSel(modeSel), .narrowSel(narrowSel), .strobes(strobes)
  );

  permDatapath u_dp (
    .dataIn(dataIn), .strobes(strobes), .resultOut(resultOut)
  );
endmodule

// File: rtl/permCheck.sv
module permCheck (
  input logic [63:0] dataIn,
  input logic [63:0] ctrlReg,
  input logic [5:0]  ctrlImm,
  input logic        useImm,
  input logic [1:0]  modeSel,
  input logic        narrowSel,
  input logic [63:0] resultOut
);
  logic [63:0] dataEff;
  logic [63:0] dataRev;
  logic [5:0]  amtSel;
  logic [5:0]  amtEff;
  logic        known;

  always_comb begin
    known = !$isunknown({dataIn, ctrlReg, ctrlImm, useImm, modeSel, narrowSel, resultOut});
    dataEff = narrowSel ? {32'h0, dataIn[31:0]} : dataIn;
    for (int i = 0; i < 64; i++) dataRev[i] = dataIn[63 - i];
    amtSel = useImm ? ctrlImm : ctrlReg[5:0];
    if (modeSel[1]) amtEff = amtSel & (narrowSel ? 6'd15 : 6'd31);
    else amtEff = amtSel & (narrowSel ? 6'd31 : 6'd63);

    if (known) begin
      assert_clear_high_R5: assert (!narrowSel || resultOut[63:32] == 32'h0)
        else $error("narrow result has upper bits set");
      assert_or_superset_R2: assert (modeSel != 2'd1 || (resultOut & dataEff) == dataEff)
        else $error("OR-combine lost a set bit");
      assert_popcount_kept_R1: assert (modeSel == 2'd1 || $countones(resultOut) == $countones(dataEff))
        else $error("permutation changed the number of ones");
      assert_zero_identity_R8: assert (amtEff != 6'd0 || resultOut == dataEff)
        else $error("zero amount altered data");
      assert_full_reverse_R9: assert (!(modeSel == 2'd0 && !narrowSel && amtSel == 6'd63) || resultOut == dataRev)
        else $error("full reverse mismatch");
    end
  end
endmodule

bind permUnit permCheck u_permCheck (
  .dataIn(dataIn), .ctrlReg(ctrlReg), .ctrlImm(ctrlImm), .useImm(useImm),
  .modeSel(modeSel), .narrowSel(narrowSel), .resultOut(resultOut)
);

// File: tb/permUnit_test.sv
module permUnit_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] dataIn = '0;
  logic [63:0] ctrlReg = '0;
  logic [5:0]  ctrlImm = '0;
  logic        useImm = 1'b0;
  logic [1:0]  modeSel = '0;
  logic        narrowSel = 1'b0;
  logic [63:0] resultOut;
  int vectors = 0;
  int miscompares = 0;
  bit finished = 0;

  always #2 clk = ~clk; // 250 MHz

  permUnit uut (
    .dataIn(dataIn), .ctrlReg(ctrlReg), .ctrlImm(ctrlImm), .useImm(useImm),
    .modeSel(modeSel), .narrowSel(narrowSel), .resultOut(resultOut)
  );

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: run did not end, got timeout expected completion");
    finishRun();
  end

  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // Exchange index bits s and s+1 of every bit position.
  function automatic logic [63:0] swapIdx(input logic [63:0] x, input int s);
    logic [63:0] y;
    for (int i = 0; i < 64; i++) begin
      int b0 = (i >> s) & 1;
      int b1 = (i >> (s + 1)) & 1;
      int j = (i & ~(3 << s)) | (b0 << (s + 1)) | (b1 << s);
      y[j] = x[i];
    end
    return y;
  endfunction

  function automatic logic [63:0] model(input int mode, input bit narrow, input int amt, input logic [63:0] din);
    logic [63:0] d, r;
    int k;
    d = din;
    if (narrow) d[63:32] = '0;
    if (mode < 2) k = amt & (narrow ? 31 : 63);
    else k = amt & (narrow ? 15 : 31);
    r = '0;
    case (mode)
      0: for (int i = 0; i < 64; i++) r[i] = d[i ^ k];
      1: for (int i = 0; i < 64; i++)
           for (int j = 0; j < 64; j++)
             if (((i ^ j) & ~k) == 0) r[i] = r[i] | d[j];
      2: begin
        r = d;
        for (int s = 4; s >= 0; s--) if ((k >> s) & 1) r = swapIdx(r, s);
      end
      default: begin
        r = d;
        for (int s = 0; s <= 4; s++) if ((k >> s) & 1) r = swapIdx(r, s);
      end
    endcase
    if (narrow) r[63:32] = '0;
    return r;
  endfunction

  task automatic apply(input int mode, input bit narrow, input bit imm, input logic [63:0] creg,
                       input logic [5:0] cimm, input logic [63:0] d, output logic [63:0] res);
    @(negedge clk);
    modeSel = 2'(mode);
    narrowSel = narrow;
    useImm = imm;
    ctrlReg = creg;
    ctrlImm = cimm;
    dataIn = d;
    @(posedge clk);
    #1;
    res = resultOut;
  endtask

  initial begin
    logic [63:0] res, mid, rev, junk;
    string tag;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    #1;
    check("R8 reset state", resultOut, 64'h0);

    // Sweep: all modes, both widths, every amount, several words (R1-R4 core, R5 narrow, R6 masking, R7 source)
    for (int mode = 0; mode < 4; mode++) begin
      for (int nw = 0; nw < 2; nw++) begin
        for (int amt = 0; amt < 64; amt++) begin
          for (int p = 0; p < 4; p++) begin
            logic [63:0] d;
            bit imm;
            d = (p == 0) ? 64'h0123456789ABCDEF : {$urandom, $urandom};
            imm = amt[0] ^ p[0];
            junk = {$urandom, $urandom};
            if (nw == 1) tag = (mode < 2) ? "R5 R6 narrow" : "R5 R6 narrow shuffle";
            else case (mode)
              0: tag = "R1 reverse";
              1: tag = "R2 OR-combine";
              2: tag = "R3 shuffle";
              default: tag = "R4 inverse shuffle";
            endcase
            if (imm) apply(mode, nw[0], 1'b1, junk, 6'(amt), d, res); // R7 ctrlReg ignored
            else apply(mode, nw[0], 1'b0, {junk[63:6], 6'(amt)}, 6'(~amt), d, res); // R7 ctrlImm ignored
            check(tag, res, model(mode, nw[0], amt, d));
          end
        end
      end
    end

    // R4: the inverse shuffle undoes the shuffle
    for (int t = 0; t < 100; t++) begin
      logic [63:0] d;
      logic [5:0] a;
      d = {$urandom, $urandom};
      a = 6'($urandom);
      apply(2, 1'b0, 1'b1, 64'h0, a, d, mid);
      apply(3, 1'b0, 1'b1, 64'h0, a, mid, res);
      check("R4 round trip", res, d);
    end

    // R8: zero amount leaves the word unchanged in every mode
    for (int mode = 0; mode < 4; mode++) begin
      apply(mode, 1'b0, 1'b0, 64'hFFFF_FFFF_FFFF_FFC0, 6'h3F, 64'hDEAD_BEEF_CAFE_F00D, res);
      check("R8 zero amount", res, 64'hDEAD_BEEF_CAFE_F00D);
    end

    // R9: full reverse
    for (int t = 0; t < 8; t++) begin
      logic [63:0] d;
      d = {$urandom, $urandom};
      for (int i = 0; i < 64; i++) rev[i] = d[63 - i];
      apply(0, 1'b0, 1'b1, 64'h0, 6'd63, d, res);
      check("R9 full reverse", res, rev);
    end

    // R10: OR-combine over everything
    apply(1, 1'b0, 1'b1, 64'h0, 6'd63, 64'h0000_1000_0000_0000, res);
    check("R10 single bit spreads", res, 64'hFFFF_FFFF_FFFF_FFFF);
    apply(1, 1'b0, 1'b1, 64'h0, 6'd63, 64'h0, res);
    check("R10 zero stays zero", res, 64'h0);

    // R5: upper data half has no effect in narrow form
    apply(0, 1'b1, 1'b1, 64'h0, 6'd31, 64'hFFFF_FFFF_0000_0001, res);
    check("R5 upper half ignored", res, 64'h0000_0000_8000_0000);

    finishRun();
  end
endmodule